// File: doc/BRIEF.md
# Stereo Zero-Crossing Detector

This block watches a tagged stream of audio samples, one sample per valid strobe, each marked as belonging to the left or the right channel. For each channel it remembers the sign of the last sample it saw. It raises a sticky per-channel flag when a new sample's sign differs from that stored sign, or when the new sample is exactly zero. Software or a neighbouring controller can use this flag to time gain or mute changes so that they do not click.

The sign position and the width of the zero test follow a run-time word-width code, so one instance serves 8, 16, 24 and 32-bit audio. Each channel has its own detect enable, its own write-1 clear strobe and its own interrupt enable. The interrupt output is the OR of every flag whose interrupt enable is set. Dropping a channel's detect enable clears that channel's flag and forgets its stored sign.

Top module: `zc_detect_top`

## Requirements
- R1: After reset both flags and the interrupt output are 0.
- R2: For width code c (0..3) the sign is sample bit 8*(c+1)-1, and only bits 8*(c+1)-1 down to 0 are tested. Bits above that field have no effect.
- R3: While a channel is enabled and has a stored sign, a valid sample for that channel whose sign differs from the stored sign sets the channel's flag on the next cycle. Every valid sample for an enabled channel updates its stored sign.
- R4: A valid sample for an enabled channel whose tested bits are all zero sets that channel's flag on the next cycle, whatever the stored sign is.
- R5: The first valid sample after a channel's enable is set only loads the stored sign. It sets no flag unless R4 applies.
- R6: The channel tag selects the channel: 0 is left (flag bit 0) and 1 is right (flag bit 1). A sample never changes the other channel's flag or stored sign.
- R7: A flag stays set until it is cleared. Driving a channel's clear bit high for one cycle clears that channel's flag on the next cycle.
- R8: If a set event and a clear for the same channel fall in the same cycle, the flag is 1 afterwards.
- R9: While a channel's detect enable is 0, its flag reads 0 from the next cycle on. Its samples are ignored, and its stored sign is forgotten.
- R10: The interrupt output is 1 exactly when some channel has both its flag and its interrupt enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 1 | Channel tag: 0 left, 1 right |
| smp_data | input | 32 | Sample, right-aligned in the word |
| width_code | input | 2 | Word width: 0=8, 1=16, 2=24, 3=32 bits |
| det_en | input | 2 | Per-channel detect enable, bit 0 left |
| irq_en | input | 2 | Per-channel interrupt enable, bit 0 left |
| clr_w1 | input | 2 | Per-channel write-1 flag clear strobe |
| zc_flag | output | 2 | Sticky zero-cross flags, bit 0 left |
| zc_irq | output | 1 | Interrupt: some enabled flag is set |

## Verification
The two functions that can meet in one cycle are a set event (a sign change or a zero sample) and the write-1 clear on the same channel. The bench drives the clear strobe during the cycle that carries a crossing sample, and expects the flag to read 1 afterwards. It also drives a clear on a cycle with no event, and expects the flag to read 0. Both cases run in the width sweep, alongside clears on the other channel. A reference model in the bench predicts every flag and the interrupt output after each cycle.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int DATA_W  = 32;
  localparam int WCODE_W = 2;
  localparam int NUM_CH  = 2;

  // Bit index of the sign for a width code: 7, 15, 23 or 31.
  function automatic int unsigned sign_pos(input logic [WCODE_W-1:0] code);
    return 8 * (int'(code) + 1) - 1;
  endfunction

  function automatic logic sample_sign(input logic [DATA_W-1:0] d,
                                       input logic [WCODE_W-1:0] code);
    return d[sign_pos(code)];
  endfunction

  // True when every bit inside the active width is zero.
  function automatic logic sample_zero(input logic [DATA_W-1:0] d,
                                       input logic [WCODE_W-1:0] code);
    logic [DATA_W-1:0] mask;
    mask = '0;
    for (int i = 0; i < DATA_W; i++)
      mask[i] = (i <= int'(sign_pos(code)));
    return (d & mask) == '0;
  endfunction
endpackage

// File: rtl/zc_chan.sv
module zc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic sgn,
  input  logic zro,
  input  logic clr,
  output logic flag
);
  logic armed_q;
  logic prev_q;
  logic flag_q;

  // Internal events brought out for checks.
  logic take;
  logic cross_ev;
  logic zero_ev;
  logic set_ev;

  assign take     = en && hit;
  assign cross_ev = take && armed_q && (sgn != prev_q);
  assign zero_ev  = take && zro;
  assign set_ev   = cross_ev || zero_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else if (!en) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (take) begin
        armed_q <= 1'b1;
        prev_q  <= sgn;
      end
      if (set_ev)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  // R9
  flag_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag);
  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr) |=> flag);
  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr && !set_ev) |=> !flag);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !set_ev) |=> $stable(flag));
  // R5
  first_sample_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !armed_q && !zro) |=> !$rose(flag));
endmodule

// File: rtl/zc_detect_top.sv
module zc_detect_top
  import zc_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_chan,
  input  logic [31:0]       smp_data,
  input  logic [1:0]        width_code,
  input  logic [1:0]        det_en,
  input  logic [1:0]        irq_en,
  input  logic [1:0]        clr_w1,
  output logic [1:0]        zc_flag,
  output logic              zc_irq
);
  logic cur_sign;
  logic cur_zero;
  logic [CH-1:0] hit_vec;
  logic [CH-1:0] flag_vec;

  assign cur_sign = sample_sign(smp_data, width_code);
  assign cur_zero = sample_zero(smp_data, width_code);

  for (genvar k = 0; k < CH; k++) begin : g_ch
    assign hit_vec[k] = smp_valid && (int'(smp_chan) == k);
    zc_chan u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (det_en[k]),
      .hit  (hit_vec[k]),
      .sgn  (cur_sign),
      .zro  (cur_zero),
      .clr  (clr_w1[k]),
      .flag (flag_vec[k])
    );
  end

  assign zc_flag = flag_vec;
  assign zc_irq  = |(flag_vec & irq_en);

  // R6
  one_channel_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zc_irq |-> (|zc_flag));
  // R1
  reset_clean_chk: assert property (@(posedge clk)
    !rst_n |=> (zc_flag == 2'b00));
endmodule

// File: tb/zc_detect_top_tb.sv
module zc_detect_top_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic smp_valid = 0;
  logic smp_chan = 0;
  logic [31:0] smp_data = 0;
  logic [1:0] width_code = 0;
  logic [1:0] det_en = 0;
  logic [1:0] irq_en = 0;
  logic [1:0] clr_w1 = 0;
  logic [1:0] zc_flag;
  logic zc_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit m_arm[2];
  bit m_prev[2];
  bit m_flag[2];

  always #2 clk = ~clk;

  zc_detect_top u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .width_code(width_code), .det_en(det_en),
    .irq_en(irq_en), .clr_w1(clr_w1), .zc_flag(zc_flag), .zc_irq(zc_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    logic [1:0] ef;
    ef = {m_flag[1], m_flag[0]};
    check(req, zc_flag, ef);
    check({req, " R10"}, zc_irq, |(ef & irq_en));
  endtask

  // One cycle of stimulus: inputs set at negedge, results checked next negedge.
  task automatic step(input bit v, input bit ch, input logic [31:0] d,
                      input logic [1:0] clr, input string req);
    longint unsigned full, low;
    bit s, z;
    full = 64'd1 << (8 * (int'(width_code) + 1));
    low  = longint'(d) % full;
    s = bit'((longint'(d) / (full / 2)) % 2);
    z = (low == 0);
    smp_valid = v; smp_chan = ch; smp_data = d; clr_w1 = clr;
    for (int k = 0; k < 2; k++) begin
      if (!det_en[k]) begin
        m_arm[k] = 0; m_flag[k] = 0;
      end else begin
        bit mine, ev;
        mine = v && (int'(ch) == k);
        ev = mine && (z || (m_arm[k] && s != m_prev[k]));
        if (mine) begin m_arm[k] = 1; m_prev[k] = s; end
        if (ev) m_flag[k] = 1;
        else if (clr[k]) m_flag[k] = 0;
      end
    end
    @(negedge clk);
    smp_valid = 0; clr_w1 = 0;
    compare_all(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    compare_all("R1");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    irq_en = 2'b11;
    det_en = 2'b11;
    step(0, 0, 0, 2'b00, "R9");
    // R5: negative first sample does not flag
    step(1, 0, 32'h80, 2'b00, "R5");
    // R3: positive next sample flags left
    step(1, 0, 32'h01, 2'b00, "R3");
    // R6: right untouched by left samples; right first sample arms only
    step(1, 1, 32'hFF, 2'b00, "R6");
    // R7: sticky, then clear
    step(0, 0, 0, 2'b00, "R7");
    step(0, 0, 0, 2'b01, "R7");
    // R8: crossing and clear together on right
    step(1, 1, 32'h05, 2'b10, "R8");
    step(0, 0, 0, 2'b10, "R7");
    // R4: zero sample flags with no sign change
    step(1, 1, 32'h00, 2'b00, "R4");
    // R10: masked interrupt
    irq_en = 2'b01;
    step(0, 0, 0, 2'b00, "R10");
    irq_en = 2'b11;
    // R9: disable clears and ignores samples
    det_en = 2'b01;
    step(1, 1, 32'h80, 2'b00, "R9");
    step(1, 1, 32'h00, 2'b00, "R9");
    det_en = 2'b11;
    // R5: after re-enable first sample only arms
    step(1, 1, 32'h7F, 2'b00, "R5");
    step(1, 1, 32'h7E, 2'b00, "R5");

    // Sweep all widths and both channels: R2 R3 R4 R6 R7 R8
    for (int wc = 0; wc < 4; wc++) begin
      width_code = 2'(wc);
      det_en = 2'b00;
      step(0, 0, 0, 2'b00, "R9");
      det_en = 2'b11;
      for (int i = 0; i < 48; i++) begin
        logic [31:0] d;
        int sp;
        logic [1:0] c;
        sp = 8 * (wc + 1) - 1;
        case (i % 6)
          0: d = 32'h1 << sp;
          1: d = 32'h1 << (sp - 1);
          2: d = (wc < 3) ? (32'hA5A5_A500 << (sp - 7)) : 32'h0;
          3: d = (32'h1 << sp) | 32'h3;
          4: d = (wc < 3) ? ~((32'h1 << (sp + 1)) - 1) : 32'h7FFF_FFFF;
          default: d = 32'(i * 32'h0101_0103);
        endcase
        c = 2'((i / 3) % 4);
        step(1, bit'((i / 2) % 2), d, c, "R2 R3 R4 R6 R8");
        if (i % 7 == 6) step(0, 0, 0, 2'b11, "R7");
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule